// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two independent request lines: a normal request and a fast request. Each line has its own enable mask, so any source can be sent to the normal line, to the fast line, to both, or to neither. Software reaches the block through a word-addressed register port. Each mask has one address that sets bits and another that clears bits, so no read-modify-write is needed. The same port also gives a masked status view and a raw view for each line.

A software-raised request is held in its own latch and merged into source 0. It stays set until software releases it, whatever the external line 0 does. Both request outputs are plain ORs of the masked level vector, so one controller's normal output can feed a source input of a parent controller to form a cascade. There is no priority encoding, no vectoring and no edge detection.

Register word addresses (the `addr_i` value): 0 normal status, 1 normal raw, 2 normal enable-set (reads back the normal mask), 3 normal enable-clear, 4 soft-raise (reads back source 0 activity in bit 0), 5 soft-release, 8 fast status, 9 fast raw, 10 fast enable-set (reads back the fast mask), 11 fast enable-clear. All other word addresses are unmapped.

Top module: `dual_line_intc`

## Requirements
- R1: After reset, both masks and the soft latch are zero, `irq_o` and `fiq_o` are low, and reads of addresses 2 and 10 return zero.
- R2: Each bit of the level vector follows its `src_i` bit one clock after the input changes. Address 1 and address 9 both return this vector, unmasked.
- R3: A write to address 2 (or 10) ORs `wdata_i` into the normal (or fast) mask. Bits written as zero keep their value.
- R4: A write to address 3 (or 11) clears each normal (or fast) mask bit where `wdata_i` has a one. All other mask bits are kept.
- R5: Address 0 reads the level vector AND the normal mask. Address 8 reads the level vector AND the fast mask.
- R6: `irq_o` is high exactly when (level AND normal mask) is nonzero, and `fiq_o` exactly when (level AND fast mask) is nonzero. Both are visible in the same cycle that the mask or level register takes its new value.
- R7: A write to address 4 with `wdata_i[0]`=1 makes source 0 active. A write to address 5 with `wdata_i[0]`=1 releases the soft request. When bit 0 is zero, neither write has any effect. A read of address 4 returns level bit 0 in bit 0 and zeros in bits 31..1.
- R8: The soft request is ORed with external `src_i[0]`. A rise and fall of the external line does not clear a pending soft request.
- R9: Writes to addresses 0, 1, 8, 9 and to unmapped addresses change neither mask nor the soft latch.
- R10: Reads of addresses 3, 5, 11 and of unmapped addresses return zero.
- R11: Writes to one line's enable addresses leave the other line's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | N_SRC | Level interrupt sources, active high |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | AW | Word address of the register access |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal request: OR of level AND normal mask |
| fiq_o | output | 1 | Fast request: OR of level AND fast mask |

## Verification
The assertions assume that `src_i`, `wr_en_i`, `addr_i` and `wdata_i` change only away from the rising edge, and that there is at most one register write per cycle. The mask properties compare the mask one cycle after a write with the data of that one write. The bench drives every input on the falling edge. Each write strobe is held for exactly one rising edge. Source levels are set up a full cycle before any check that depends on them. The bench waits for the internal reset release before it makes any access.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IRQ_STAT,
    SEL_IRQ_RAW,
    SEL_IRQ_EN,
    SEL_IRQ_DIS,
    SEL_SOFT_ON,
    SEL_SOFT_OFF,
    SEL_FIQ_STAT,
    SEL_FIQ_RAW,
    SEL_FIQ_EN,
    SEL_FIQ_DIS
  } reg_sel_e;

  // Word-address decode; the word numbers form the software-visible map.
  function automatic reg_sel_e decode_word(input logic [31:0] w);
    reg_sel_e s;
    case (w)
      32'd0:   s = SEL_IRQ_STAT;
      32'd1:   s = SEL_IRQ_RAW;
      32'd2:   s = SEL_IRQ_EN;
      32'd3:   s = SEL_IRQ_DIS;
      32'd4:   s = SEL_SOFT_ON;
      32'd5:   s = SEL_SOFT_OFF;
      32'd8:   s = SEL_FIQ_STAT;
      32'd9:   s = SEL_FIQ_RAW;
      32'd10:  s = SEL_FIQ_EN;
      32'd11:  s = SEL_FIQ_DIS;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         upd;

  assign upd = set_i | clr_i;

  always_comb begin
    mask_d = mask_q;
    if (set_i) mask_d = mask_d | bits_i;
    if (clr_i) mask_d = mask_d & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (upd) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/intc_level_capture.sv
module intc_level_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         soft_on_i,
  input  logic         soft_off_i,
  output logic [W-1:0] level_o
);

  logic [W-1:0] src_q;
  logic         soft_q;
  logic         soft_d;
  logic         soft_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
    end else begin
      src_q <= src_i;
    end
  end

  assign soft_upd = soft_on_i | soft_off_i;

  always_comb begin
    soft_d = soft_q;
    if (soft_on_i)  soft_d = 1'b1;
    if (soft_off_i) soft_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_q <= 1'b0;
    end else if (soft_upd) begin
      soft_q <= soft_d;
    end
  end

  always_comb begin
    level_o    = src_q;
    level_o[0] = src_q[0] | soft_q;
  end

endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] irq_mask_i,
  input  logic [W-1:0] fiq_mask_i,
  output logic [W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_IRQ_STAT: rdata_o = level_i & irq_mask_i;
      SEL_IRQ_RAW:  rdata_o = level_i;
      SEL_IRQ_EN:   rdata_o = irq_mask_i;
      SEL_SOFT_ON:  rdata_o[0] = level_i[0];
      SEL_FIQ_STAT: rdata_o = level_i & fiq_mask_i;
      SEL_FIQ_RAW:  rdata_o = level_i;
      SEL_FIQ_EN:   rdata_o = fiq_mask_i;
      default:      rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);

  logic             rst_int_n;
  logic [31:0]      addr_ext;
  reg_sel_e         sel;
  logic [N_SRC-1:0] level_vec;
  logic [N_SRC-1:0] irq_mask;
  logic [N_SRC-1:0] fiq_mask;
  logic             wr_irq_set, wr_irq_clr, wr_fiq_set, wr_fiq_clr;
  logic             wr_soft_on, wr_soft_off;

  intc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  assign addr_ext = 32'(addr_i);
  assign sel      = decode_word(addr_ext);

  assign wr_irq_set  = wr_en_i && (sel == SEL_IRQ_EN);
  assign wr_irq_clr  = wr_en_i && (sel == SEL_IRQ_DIS);
  assign wr_fiq_set  = wr_en_i && (sel == SEL_FIQ_EN);
  assign wr_fiq_clr  = wr_en_i && (sel == SEL_FIQ_DIS);
  assign wr_soft_on  = wr_en_i && (sel == SEL_SOFT_ON)  && wdata_i[0];
  assign wr_soft_off = wr_en_i && (sel == SEL_SOFT_OFF) && wdata_i[0];

  intc_level_capture #(.W(N_SRC)) u_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .src_i      (src_i),
    .soft_on_i  (wr_soft_on),
    .soft_off_i (wr_soft_off),
    .level_o    (level_vec)
  );

  intc_mask_reg #(.W(N_SRC)) u_irq_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .set_i  (wr_irq_set),
    .clr_i  (wr_irq_clr),
    .bits_i (wdata_i),
    .mask_o (irq_mask)
  );

  intc_mask_reg #(.W(N_SRC)) u_fiq_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .set_i  (wr_fiq_set),
    .clr_i  (wr_fiq_clr),
    .bits_i (wdata_i),
    .mask_o (fiq_mask)
  );

  intc_read_mux #(.W(N_SRC)) u_rd (
    .sel_i      (sel),
    .level_i    (level_vec),
    .irq_mask_i (irq_mask),
    .fiq_mask_i (fiq_mask),
    .rdata_o    (rdata_o)
  );

  assign irq_o = |(level_vec & irq_mask);
  assign fiq_o = |(level_vec & fiq_mask);

endmodule

// File: rtl/dual_line_intc_chk.sv
module dual_line_intc_chk #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned AW    = 6
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [N_SRC-1:0] wdata_i,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [N_SRC-1:0] lvl,
  input logic [N_SRC-1:0] irq_m,
  input logic [N_SRC-1:0] fiq_m
);

  localparam logic [AW-1:0] A_ISTAT = AW'(0);
  localparam logic [AW-1:0] A_IRAW  = AW'(1);
  localparam logic [AW-1:0] A_IEN   = AW'(2);
  localparam logic [AW-1:0] A_IDIS  = AW'(3);
  localparam logic [AW-1:0] A_SON   = AW'(4);
  localparam logic [AW-1:0] A_FSTAT = AW'(8);
  localparam logic [AW-1:0] A_FRAW  = AW'(9);
  localparam logic [AW-1:0] A_FEN   = AW'(10);
  localparam logic [AW-1:0] A_FDIS  = AW'(11);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IRQ_FOLLOWS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o == |(lvl & irq_m)); // R6
  AST_FIQ_FOLLOWS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    fiq_o == |(lvl & fiq_m)); // R6
  AST_IRQ_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == A_IEN) |=> ((irq_m & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_FIQ_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == A_FEN) |=> ((fiq_m & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_IRQ_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == A_IDIS) |=> ((irq_m & $past(wdata_i)) == '0)); // R4
  AST_FIQ_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == A_FDIS) |=> ((fiq_m & $past(wdata_i)) == '0)); // R4
  AST_VIEW_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && (addr_i == A_ISTAT || addr_i == A_IRAW || addr_i == A_FSTAT || addr_i == A_FRAW))
    |=> ($stable(irq_m) && $stable(fiq_m))); // R9
  AST_FIQ_WRITE_KEEPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && (addr_i == A_FEN || addr_i == A_FDIS)) |=> $stable(irq_m)); // R11
  AST_SRC_TRACKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    past_ok |-> (lvl[N_SRC-1:1] == $past(src_i[N_SRC-1:1]))); // R2
  AST_EXT0_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (past_ok && $past(src_i[0])) |-> lvl[0]); // R8
  AST_SOFT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == A_SON && wdata_i[0]) |=> lvl[0]); // R7

endmodule

bind dual_line_intc dual_line_intc_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_int_n),
  .src_i   (src_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .lvl     (level_vec),
  .irq_m   (irq_mask),
  .fiq_m   (fiq_mask)
);

// File: tb/dual_line_intc_tb.sv
module dual_line_intc_tb_top;

  localparam int unsigned N  = 32;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata;
  logic [N-1:0]  rdata;
  logic          irq, fiq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  dual_line_intc #(.N_SRC(N), .AW(AW)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq),
    .fiq_o   (fiq)
  );

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic drive_src(input logic [N-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    chk("R1 irq low", {31'b0, irq}, '0);
    chk("R1 fiq low", {31'b0, fiq}, '0);
    rd(2, d);  chk("R1 irq mask", d, '0);
    rd(10, d); chk("R1 fiq mask", d, '0);
    rd(4, d);  chk("R1 soft", d, '0);
  endtask

  task automatic t_levels();
    logic [N-1:0] d;
    drive_src(32'hA5A5_0F00);
    rd(1, d); chk("R2 raw A", d, 32'hA5A5_0F00);
    rd(9, d); chk("R2 raw fast view", d, 32'hA5A5_0F00);
    drive_src(32'h8000_0001);
    rd(1, d); chk("R2 raw B", d, 32'h8000_0001);
    drive_src('0);
    rd(1, d); chk("R2 raw cleared", d, '0);
  endtask

  task automatic t_masks();
    logic [N-1:0] d;
    wr(2, 32'h0000_00F0);
    wr(2, 32'h0000_0F00);
    rd(2, d);  chk("R3 irq or", d, 32'h0000_0FF0);
    rd(10, d); chk("R11 fiq untouched", d, '0);
    wr(3, 32'h0000_00F0);
    rd(2, d);  chk("R4 irq clr", d, 32'h0000_0F00);
    wr(10, 32'h8000_0003);
    rd(10, d); chk("R3 fiq set", d, 32'h8000_0003);
    rd(2, d);  chk("R11 irq untouched", d, 32'h0000_0F00);
    wr(11, 32'h0000_0001);
    rd(10, d); chk("R4 fiq clr", d, 32'h8000_0002);
  endtask

  task automatic t_status();
    logic [N-1:0] d;
    // irq mask 0x0F00, fiq mask 0x80000002
    drive_src(32'h8000_0300);
    rd(0, d); chk("R5 irq stat", d, 32'h0000_0300);
    rd(8, d); chk("R5 fiq stat", d, 32'h8000_0000);
    chk("R6 irq high", {31'b0, irq}, 32'd1);
    chk("R6 fiq high", {31'b0, fiq}, 32'd1);
    wr(3, 32'h0000_0F00);
    chk("R6 irq drops with mask", {31'b0, irq}, '0);
    drive_src(32'h0000_0004);
    chk("R6 fiq low", {31'b0, fiq}, '0);
    wr(10, 32'h0000_0004);
    chk("R6 fiq rises with mask", {31'b0, fiq}, 32'd1);
    wr(11, 32'hFFFF_FFFF);
    drive_src('0);
  endtask

  task automatic t_soft();
    logic [N-1:0] d;
    wr(4, 32'h0000_0002);
    rd(4, d); chk("R7 bit0 low ignored", d, '0);
    wr(2, 32'h0000_0001);
    wr(4, 32'h0000_0001);
    rd(4, d); chk("R7 soft on", d, 32'd1);
    rd(1, d); chk("R7 raw bit0", d, 32'd1);
    chk("R7 irq from soft", {31'b0, irq}, 32'd1);
    drive_src(32'h0000_0001);
    drive_src('0);
    rd(4, d); chk("R8 soft survives ext pulse", d, 32'd1);
    wr(5, 32'h0000_0000);
    rd(4, d); chk("R7 clr bit0 low ignored", d, 32'd1);
    wr(5, 32'h0000_0001);
    rd(4, d); chk("R7 soft off", d, '0);
    drive_src(32'h0000_0001);
    wr(4, 32'h0000_0001);
    wr(5, 32'h0000_0001);
    rd(4, d); chk("R8 ext still active", d, 32'd1);
    drive_src('0);
    rd(4, d); chk("R8 released", d, '0);
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_bad_write();
    logic [N-1:0] d;
    wr(2, 32'h0000_1234);
    wr(10, 32'h0000_5678);
    foreach (bad_w[i]) wr(bad_w[i], 32'hFFFF_FFFF);
    rd(2, d);  chk("R9 irq mask kept", d, 32'h0000_1234);
    rd(10, d); chk("R9 fiq mask kept", d, 32'h0000_5678);
    rd(4, d);  chk("R9 soft kept", d, '0);
  endtask

  int bad_w[7] = '{0, 1, 8, 9, 6, 12, 63};
  int bad_r[7] = '{3, 5, 11, 6, 7, 12, 63};

  task automatic t_bad_read();
    logic [N-1:0] d;
    drive_src(32'hFFFF_FFFF);
    foreach (bad_r[i]) begin
      rd(bad_r[i], d);
      chk($sformatf("R10 read %0d zero", bad_r[i]), d, '0);
    end
    drive_src('0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_levels();
    t_masks();
    t_status();
    t_soft();
    t_bad_write();
    t_bad_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule